// File: doc/BRIEF.md
# Sensor Command Word Serializer

This block assembles the configuration word of an image sensor readout chip from a set of field inputs and sends it to the sensor over a single data line with its own serial clock. The word is 103 bits long. It always opens with a fixed four-bit header, and the configuration fields follow in a fixed order. The first bit of the word leaves first. Data moves on the falling edge of the serial clock, so the sensor can sample it on the rising edge.

A transfer starts with a single-cycle request. The request is refused when the sensor is integrating, because the whole word has to arrive before integration begins. It is also refused when a custom window asks for coordinates that the chosen channel count cannot read out. Each refusal sets its own error flag, and no bits go out. On every accepted request the block also works out which readout mode the word selects, using the priority rules between the mode bits, and holds that result on an output.

Top module: `cmdword_serializer`

## Requirements
- R1: After reset `busy`, `ser_clk`, `ser_data`, `err_window` and `err_integ` are 0, and `read_mode` is 0 (CDS).
- R2: The word is sent most significant bit first, in this order: header 1,1,0,1; `gain_sel`[1:0]; `flip_col`; `flip_row`; `win_preset`[1:0]; `col_lo`, `col_hi`, `row_lo` and `row_hi` (9 bits each); `pwr_cfg`[16:15]; `chan_sel`[1:0]; `pwr_cfg`[14:0]; `test_bits`[29:25]; `cds_time`[3:0]; `test_bits`[24]; `cds_on`; `hold_on`; `multi_on`; `bw_limit`; `test_bits`[23:0].
- R3: Each bit takes 2·HALF clock cycles: `ser_clk` is low for HALF cycles, then high for HALF cycles. There are exactly 103 rising edges per transfer. `ser_data` changes only while `ser_clk` is low, and `ser_clk` stays low when no transfer runs.
- R4: An accepted request sets `busy` on the same edge. `busy` stays high for 2·HALF·103 cycles and falls on the final falling edge of `ser_clk`.
- R5: A request made while `integ_busy` is 1 is refused. `err_integ` becomes 1 and no transfer starts.
- R6: When `win_preset` is 00 (custom window), the request is refused with `err_window` = 1 in any of these cases: `row_lo` is above 508, `row_hi` is above 511, or `row_hi` < `row_lo`+3 (the window must be at least four rows tall).
- R7: For a custom window, the column limits depend on `chan_sel`. For 0x (2 channels) `col_lo` ≤ 318 and `col_hi` ≤ 319. For 10 (4 channels) the limits are 158 and 159. For 11 (8 channels) they are 78 and 79. In every case `col_hi` ≥ `col_lo`+1. A violation sets `err_window` and refuses the request. When `win_preset` is not 00, no window check is made.
- R8: `read_mode` changes only on an accepted request. Its codes are: 0 CDS, 1 non-CDS, 2 hold-read with CDS, 3 hold-read without CDS, 4 multi-integration with CDS, 5 multi-integration without CDS. `multi_on` wins over `hold_on`, and `hold_on` wins over CDS. CDS is in effect only when `cds_on` is 1 and `gain_sel`[1] is 0.
- R9: A request made while `busy` is high is ignored. The error flags keep their values and the running transfer continues unchanged.
- R10: Each request made while idle writes both error flags afresh. When the integration refusal and the window refusal apply to the same request, both flags are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_req | input | 1 | Single-cycle transfer request |
| integ_busy | input | 1 | Sensor integration in progress |
| gain_sel | input | 2 | Gain field |
| flip_col | input | 1 | Column order flip |
| flip_row | input | 1 | Row order flip |
| win_preset | input | 2 | Window preset, 00 means custom |
| col_lo | input | 9 | Custom window first column unit |
| col_hi | input | 9 | Custom window last column unit |
| row_lo | input | 9 | Custom window first row |
| row_hi | input | 9 | Custom window last row |
| chan_sel | input | 2 | Output channel count field |
| pwr_cfg | input | 17 | Power, timing and anti-blooming fields |
| cds_time | input | 4 | CDS sampling time field |
| cds_on | input | 1 | CDS mode bit |
| hold_on | input | 1 | Hold-read mode bit |
| multi_on | input | 1 | Multi-integration mode bit |
| bw_limit | input | 1 | Output bandwidth limit bit |
| test_bits | input | 30 | Test fields |
| ser_clk | output | 1 | Serial clock to the sensor |
| ser_data | output | 1 | Serial data to the sensor |
| busy | output | 1 | Transfer in progress |
| err_window | output | 1 | Last request refused for its window |
| err_integ | output | 1 | Last request refused during integration |
| read_mode | output | 3 | Decoded readout mode of the last accepted word |

## Verification
Two refusals can fall on the same request: the integration guard and the window range check. The bench raises `integ_busy` while the custom coordinates are also out of range. It expects both flags to be set, no clock edge on the serial line, and `read_mode` left unchanged. A second clash comes from a request made in the middle of a transfer. The bench makes one with fields that would be refused, then checks that the flags did not move and that the captured word still matches the first request.

// File: rtl/cmdw_pkg.sv
`timescale 1ns/1ps
package cmdw_pkg;
  localparam int WORD_W  = 103;
  localparam int COORD_W = 9;
  localparam logic [3:0] HEADER = 4'b1101;

  typedef enum logic [2:0] {
    RM_CDS         = 3'd0,
    RM_PLAIN       = 3'd1,
    RM_HOLD_CDS    = 3'd2,
    RM_HOLD_PLAIN  = 3'd3,
    RM_MULTI_CDS   = 3'd4,
    RM_MULTI_PLAIN = 3'd5
  } rmode_e;

  // Payload fields in transmit order (header excluded)
  typedef struct packed {
    logic [1:0]         gain;
    logic               flip_col;
    logic               flip_row;
    logic [1:0]         preset;
    logic [COORD_W-1:0] col_lo;
    logic [COORD_W-1:0] col_hi;
    logic [COORD_W-1:0] row_lo;
    logic [COORD_W-1:0] row_hi;
    logic [1:0]         pwr_glob;
    logic [1:0]         chan;
    logic [14:0]        bias;
    logic [4:0]         tst_a;
    logic [3:0]         cds_time;
    logic               tst_b;
    logic               cds_on;
    logic               hold_on;
    logic               multi_on;
    logic               bw_limit;
    logic [23:0]        tst_c;
  } cfg_t;
endpackage

// File: rtl/cmdw_window_check.sv
`timescale 1ns/1ps
module cmdw_window_check #(
  parameter int ROWS = 512,
  parameter int COLS = 640,
  parameter int CW   = 9
) (
  input  logic [1:0]    preset,
  input  logic [1:0]    chan,
  input  logic [CW-1:0] col_lo,
  input  logic [CW-1:0] col_hi,
  input  logic [CW-1:0] row_lo,
  input  logic [CW-1:0] row_hi,
  output logic          bad
);
  localparam int MIN_ROWS   = 4;
  localparam int ROW_LO_MAX = ROWS - MIN_ROWS;
  localparam int ROW_HI_MAX = ROWS - 1;
  localparam int NOPT       = 3;
  localparam int XW         = CW + 1;

  logic [XW-1:0] cs_lim [NOPT];
  logic [XW-1:0] cf_lim [NOPT];

  // one limit pair per channel option: 2, 4, 8 channels
  generate
    for (genvar g = 0; g < NOPT; g++) begin : g_lim
      localparam int UNITS = COLS / (2 << g);
      assign cs_lim[g] = XW'(UNITS - 2);
      assign cf_lim[g] = XW'(UNITS - 1);
    end
  endgenerate

  logic [1:0]    sel;
  logic [XW-1:0] cl, ch, rl, rh;
  logic          row_bad, col_bad;

  always_comb begin
    sel = chan[1] ? (chan[0] ? 2'd2 : 2'd1) : 2'd0;
    cl  = {1'b0, col_lo};
    ch  = {1'b0, col_hi};
    rl  = {1'b0, row_lo};
    rh  = {1'b0, row_hi};
    row_bad = (rl > XW'(ROW_LO_MAX)) || (rh > XW'(ROW_HI_MAX)) ||
              (rh < rl + XW'(MIN_ROWS - 1));
    col_bad = (cl > cs_lim[sel]) || (ch > cf_lim[sel]) || (ch <= cl);
    bad     = (preset == 2'b00) && (row_bad || col_bad);
  end
endmodule

// File: rtl/cmdw_mode_decode.sv
`timescale 1ns/1ps
module cmdw_mode_decode
  import cmdw_pkg::*;
(
  input  logic   gain_hi,
  input  logic   cds_on,
  input  logic   hold_on,
  input  logic   multi_on,
  output rmode_e mode
);
  logic cds_eff;

  always_comb begin
    cds_eff = cds_on & ~gain_hi;
    if (multi_on)      mode = cds_eff ? RM_MULTI_CDS : RM_MULTI_PLAIN;
    else if (hold_on)  mode = cds_eff ? RM_HOLD_CDS  : RM_HOLD_PLAIN;
    else               mode = cds_eff ? RM_CDS       : RM_PLAIN;
  end
endmodule

// File: rtl/cmdw_shift_engine.sv
`timescale 1ns/1ps
module cmdw_shift_engine #(
  parameter int W    = 103,
  parameter int HALF = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] word,
  output logic         ser_clk,
  output logic         ser_data,
  output logic         busy
);
  localparam int BW = $clog2(W);
  localparam int DW = $clog2(HALF + 1);

  logic [W-1:0]  sh_q, sh_n;
  logic [BW-1:0] bit_q, bit_n;
  logic [DW-1:0] div_q, div_n;
  logic          sclk_q, sclk_n;
  logic          busy_q, busy_n;

  always_comb begin
    sh_n   = sh_q;
    bit_n  = bit_q;
    div_n  = div_q;
    sclk_n = sclk_q;
    busy_n = busy_q;
    if (!busy_q) begin
      if (start) begin
        busy_n = 1'b1;
        sh_n   = word;
        bit_n  = '0;
        div_n  = '0;
        sclk_n = 1'b0;
      end
    end else if (div_q == DW'(HALF - 1)) begin
      div_n = '0;
      if (!sclk_q) begin
        sclk_n = 1'b1;
      end else begin
        sclk_n = 1'b0;
        if (bit_q == BW'(W - 1)) begin
          busy_n = 1'b0;
          sh_n   = '0;
        end else begin
          bit_n = bit_q + 1'b1;
          sh_n  = {sh_q[W-2:0], 1'b0};
        end
      end
    end else begin
      div_n = div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      bit_q  <= '0;
      div_q  <= '0;
      sclk_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      sh_q   <= sh_n;
      bit_q  <= bit_n;
      div_q  <= div_n;
      sclk_q <= sclk_n;
      busy_q <= busy_n;
    end
  end

  assign ser_clk  = sclk_q;
  assign ser_data = sh_q[W-1];
  assign busy     = busy_q;
endmodule

// File: rtl/cmdword_serializer.sv
`timescale 1ns/1ps
module cmdword_serializer
  import cmdw_pkg::*;
#(
  parameter int HALF = 2,
  parameter int ROWS = 512,
  parameter int COLS = 640
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load_req,
  input  logic        integ_busy,
  input  logic [1:0]  gain_sel,
  input  logic        flip_col,
  input  logic        flip_row,
  input  logic [1:0]  win_preset,
  input  logic [8:0]  col_lo,
  input  logic [8:0]  col_hi,
  input  logic [8:0]  row_lo,
  input  logic [8:0]  row_hi,
  input  logic [1:0]  chan_sel,
  input  logic [16:0] pwr_cfg,
  input  logic [3:0]  cds_time,
  input  logic        cds_on,
  input  logic        hold_on,
  input  logic        multi_on,
  input  logic        bw_limit,
  input  logic [29:0] test_bits,
  output logic        ser_clk,
  output logic        ser_data,
  output logic        busy,
  output logic        err_window,
  output logic        err_integ,
  output logic [2:0]  read_mode
);
  cfg_t              cfg;
  logic [WORD_W-1:0] word;
  logic              win_bad;
  rmode_e            mode_dec;
  logic              req_en, accept;
  logic              ew_q, ew_n, ei_q, ei_n;
  rmode_e            mode_q, mode_n;

  always_comb begin
    cfg.gain     = gain_sel;
    cfg.flip_col = flip_col;
    cfg.flip_row = flip_row;
    cfg.preset   = win_preset;
    cfg.col_lo   = col_lo;
    cfg.col_hi   = col_hi;
    cfg.row_lo   = row_lo;
    cfg.row_hi   = row_hi;
    cfg.pwr_glob = pwr_cfg[16:15];
    cfg.chan     = chan_sel;
    cfg.bias     = pwr_cfg[14:0];
    cfg.tst_a    = test_bits[29:25];
    cfg.cds_time = cds_time;
    cfg.tst_b    = test_bits[24];
    cfg.cds_on   = cds_on;
    cfg.hold_on  = hold_on;
    cfg.multi_on = multi_on;
    cfg.bw_limit = bw_limit;
    cfg.tst_c    = test_bits[23:0];
    word         = {HEADER, cfg};
  end

  cmdw_window_check #(.ROWS(ROWS), .COLS(COLS), .CW(COORD_W)) u_win (
    .preset (win_preset),
    .chan   (chan_sel),
    .col_lo (col_lo),
    .col_hi (col_hi),
    .row_lo (row_lo),
    .row_hi (row_hi),
    .bad    (win_bad)
  );

  cmdw_mode_decode u_mode (
    .gain_hi  (gain_sel[1]),
    .cds_on   (cds_on),
    .hold_on  (hold_on),
    .multi_on (multi_on),
    .mode     (mode_dec)
  );

  // next-state for request outcome
  always_comb begin
    req_en = load_req & ~busy;
    accept = req_en & ~integ_busy & ~win_bad;
    ew_n   = req_en ? win_bad    : ew_q;
    ei_n   = req_en ? integ_busy : ei_q;
    mode_n = accept ? mode_dec   : mode_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ew_q   <= 1'b0;
      ei_q   <= 1'b0;
      mode_q <= RM_CDS;
    end else begin
      ew_q   <= ew_n;
      ei_q   <= ei_n;
      mode_q <= mode_n;
    end
  end

  cmdw_shift_engine #(.W(WORD_W), .HALF(HALF)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept),
    .word     (word),
    .ser_clk  (ser_clk),
    .ser_data (ser_data),
    .busy     (busy)
  );

  assign err_window = ew_q;
  assign err_integ  = ei_q;
  assign read_mode  = mode_q;
endmodule

// File: rtl/cmdword_serializer_chk.sv
`timescale 1ns/1ps
module cmdword_serializer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       load_req,
  input logic       integ_busy,
  input logic       busy,
  input logic       ser_clk,
  input logic       ser_data,
  input logic       err_window,
  input logic       err_integ,
  input logic [2:0] read_mode
);
  logic       sclk_d;
  logic [7:0] rise_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d   <= 1'b0;
      rise_cnt <= '0;
    end else begin
      sclk_d <= ser_clk;
      if (!busy)                  rise_cnt <= '0;
      else if (ser_clk && !sclk_d) rise_cnt <= rise_cnt + 1'b1;
    end
  end

  // R3: data held while serial clock high
  a_r3_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk && sclk_d) |-> $stable(ser_data));

  // R3: idle line has no clock
  a_r3_idle_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !ser_clk);

  // R3: full bit count at the end of a transfer
  a_r3_bit_count: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> rise_cnt == 8'd103);

  // R4 / R5: a transfer starts only from a request outside integration
  a_r4_start_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(load_req) && !$past(integ_busy)));

  // R5: request during integration refused
  a_r5_integ_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (load_req && !busy && integ_busy) |=> (!busy && err_integ));

  // R6: accepted transfer carries no window error
  a_r6_no_err_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !err_window);

  // R8: mode moves only on a started transfer
  a_r8_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(read_mode) |-> $rose(busy));

  // R9: request while busy leaves flags alone
  a_r9_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && load_req) |=> ($stable(err_window) && $stable(err_integ)));
endmodule

bind cmdword_serializer cmdword_serializer_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .load_req   (load_req),
  .integ_busy (integ_busy),
  .busy       (busy),
  .ser_clk    (ser_clk),
  .ser_data   (ser_data),
  .err_window (err_window),
  .err_integ  (err_integ),
  .read_mode  (read_mode)
);

// File: tb/cmdword_serializer_tb_top.sv
`timescale 1ns/1ps
module cmdword_serializer_tb_top;
  localparam int HALF = 2;
  localparam int W    = 103;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, load_req, integ_busy;
  logic [1:0]  gain_sel, win_preset, chan_sel;
  logic        flip_col, flip_row, cds_on, hold_on, multi_on, bw_limit;
  logic [8:0]  col_lo, col_hi, row_lo, row_hi;
  logic [16:0] pwr_cfg;
  logic [3:0]  cds_time;
  logic [29:0] test_bits;
  logic        ser_clk, ser_data, busy, err_window, err_integ;
  logic [2:0]  read_mode;

  cmdword_serializer #(.HALF(HALF)) dut_i (.*);

  int n_chk = 0, n_bad = 0;
  int last_mode = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] exp_word();
    return {4'b1101, gain_sel, flip_col, flip_row, win_preset, col_lo, col_hi,
            row_lo, row_hi, pwr_cfg[16:15], chan_sel, pwr_cfg[14:0],
            test_bits[29:25], cds_time, test_bits[24], cds_on, hold_on,
            multi_on, bw_limit, test_bits[23:0]};
  endfunction

  function automatic int units_of(logic [1:0] c);
    return c[1] ? (c[0] ? 80 : 160) : 320;
  endfunction

  function automatic bit exp_win_bad();
    int u;
    u = units_of(chan_sel);
    if (win_preset != 2'b00) return 0;
    return (int'(row_lo) > 508) || (int'(row_hi) > 511) ||
           (int'(row_hi) < int'(row_lo) + 3) || (int'(col_lo) > u - 2) ||
           (int'(col_hi) > u - 1) || (int'(col_hi) < int'(col_lo) + 1);
  endfunction

  function automatic int exp_mode();
    bit c;
    c = cds_on && !gain_sel[1];
    if (multi_on) return c ? 4 : 5;
    if (hold_on)  return c ? 2 : 3;
    return c ? 0 : 1;
  endfunction

  task automatic rand_fields(input bit valid_win);
    int u, a;
    gain_sel = 2'($urandom); flip_col = 1'($urandom); flip_row = 1'($urandom);
    win_preset = 2'($urandom_range(0, 3)) & {2{$urandom_range(0, 1) == 1}};
    chan_sel = 2'($urandom); pwr_cfg = 17'($urandom); cds_time = 4'($urandom);
    cds_on = 1'($urandom); hold_on = 1'($urandom); multi_on = 1'($urandom);
    bw_limit = 1'($urandom); test_bits = 30'($urandom);
    u = units_of(chan_sel);
    if (valid_win) begin
      a = $urandom_range(0, u - 2);      col_lo = 9'(a);
      col_hi = 9'($urandom_range(a + 1, u - 1));
      a = $urandom_range(0, 508);        row_lo = 9'(a);
      row_hi = 9'($urandom_range(a + 3, 511));
    end else begin
      col_lo = 9'($urandom); col_hi = 9'($urandom);
      row_lo = 9'($urandom); row_hi = 9'($urandom);
    end
  endtask

  task automatic set_win(input logic [1:0] ch, input int cl, input int chh,
                         input int rl, input int rh);
    win_preset = 2'b00; chan_sel = ch;
    col_lo = 9'(cl); col_hi = 9'(chh); row_lo = 9'(rl); row_hi = 9'(rh);
  endtask

  task automatic do_load(input string tag, input bit poke);
    bit e_i, e_w, acc, prev, prev_d, stab;
    logic [W-1:0] e_word, cap;
    int e_m, cyc, nb;
    e_i = integ_busy; e_w = exp_win_bad(); acc = !e_i && !e_w;
    e_word = exp_word(); e_m = exp_mode();
    @(negedge clk) load_req = 1'b1;
    @(negedge clk) load_req = 1'b0;
    chk(err_integ == e_i, {tag, " R5 R10 err_integ"}, W'(err_integ), W'(e_i));
    chk(err_window == e_w, {tag, " R6 R7 R10 err_window"}, W'(err_window), W'(e_w));
    if (acc) begin
      chk(busy == 1'b1, {tag, " R4 busy set"}, W'(busy), W'(1));
      chk(int'(read_mode) == e_m, {tag, " R8 mode"}, W'(read_mode), W'(e_m));
      last_mode = e_m;
      cyc = 0; nb = 0; prev = 0; prev_d = 0; stab = 1; cap = '0;
      while (busy && cyc < 5000) begin
        if (ser_clk && !prev) begin cap = {cap[W-2:0], ser_data}; nb++; end
        if (ser_clk && prev && ser_data != prev_d) stab = 0;
        prev = ser_clk; prev_d = ser_data;
        if (poke && cyc == 50) begin
          integ_busy = 1'b1; row_lo = 9'd511; win_preset = 2'b00; load_req = 1'b1;
        end
        if (poke && cyc == 51) begin integ_busy = 1'b0; load_req = 1'b0; end
        cyc++;
        @(negedge clk);
      end
      chk(cyc == 2 * HALF * W, {tag, " R4 busy length"}, W'(cyc), W'(2 * HALF * W));
      chk(nb == W, {tag, " R3 rising edges"}, W'(nb), W'(W));
      chk(stab, {tag, " R3 data stable while high"}, W'(stab), W'(1));
      chk(cap == e_word, {tag, " R2 word"}, cap, e_word);
      chk(!ser_clk, {tag, " R3 idle clock"}, W'(ser_clk), W'(0));
      if (poke) begin
        chk(err_integ == 1'b0 && err_window == 1'b0, {tag, " R9 flags kept"},
            W'({err_integ, err_window}), W'(0));
      end
    end else begin
      nb = 0;
      for (int k = 0; k < 4 * HALF; k++) begin
        if (ser_clk || busy) nb++;
        @(negedge clk);
      end
      chk(nb == 0, {tag, " R5 R6 no transfer"}, W'(nb), W'(0));
      chk(int'(read_mode) == last_mode, {tag, " R8 mode kept"}, W'(read_mode),
          W'(last_mode));
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_c0de));
    rst_n = 1'b0; load_req = 1'b0; integ_busy = 1'b0;
    rand_fields(1'b1); win_preset = 2'b11;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !ser_clk && !ser_data && !err_window && !err_integ && read_mode == 3'd0,
        "R1 reset state", W'({busy, ser_clk, ser_data, err_window, err_integ, read_mode}), W'(0));

    // directed: preset window, all mode bits off
    rand_fields(1'b1); win_preset = 2'b11; cds_on = 1; hold_on = 0; multi_on = 0;
    gain_sel = 2'b00; do_load("preset", 0);
    // R6 row boundaries
    rand_fields(1'b1); set_win(2'b11, 0, 79, 508, 511); do_load("R6 rows edge ok", 0);
    rand_fields(1'b1); set_win(2'b11, 0, 79, 509, 511); do_load("R6 row_lo 509", 0);
    rand_fields(1'b1); set_win(2'b11, 0, 79, 10, 12);   do_load("R6 three rows", 0);
    // R7 column limits for every channel count
    rand_fields(1'b1); set_win(2'b01, 318, 319, 0, 3);  do_load("R7 2ch edge", 0);
    rand_fields(1'b1); set_win(2'b00, 319, 319, 0, 3);  do_load("R7 2ch lo 319", 0);
    rand_fields(1'b1); set_win(2'b10, 158, 159, 0, 3);  do_load("R7 4ch edge", 0);
    rand_fields(1'b1); set_win(2'b10, 0, 160, 0, 3);    do_load("R7 4ch hi 160", 0);
    rand_fields(1'b1); set_win(2'b11, 78, 79, 0, 3);    do_load("R7 8ch edge", 0);
    rand_fields(1'b1); set_win(2'b11, 0, 80, 0, 3);     do_load("R7 8ch hi 80", 0);
    rand_fields(1'b1); set_win(2'b11, 5, 5, 0, 3);      do_load("R7 hi equals lo", 0);
    // R10 both refusals in one request
    rand_fields(1'b1); set_win(2'b11, 0, 200, 0, 3); integ_busy = 1;
    do_load("R10 both errors", 0); integ_busy = 0;
    // R5 integration alone
    rand_fields(1'b1); integ_busy = 1; do_load("R5 integ", 0); integ_busy = 0;
    // R8 priority cases
    rand_fields(1'b1); multi_on = 1; hold_on = 1; cds_on = 1; gain_sel = 2'b01;
    do_load("R8 multi over hold", 0);
    rand_fields(1'b1); multi_on = 0; hold_on = 1; cds_on = 1; gain_sel = 2'b10;
    do_load("R8 gain overrides cds", 0);
    // R9 request in the middle of a transfer
    rand_fields(1'b1); do_load("R9 mid request", 1);
    // random mix
    for (int i = 0; i < 30; i++) begin
      rand_fields($urandom_range(0, 9) < 7);
      integ_busy = ($urandom_range(0, 9) == 0);
      do_load("random", 0);
      integ_busy = 0;
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R4 act=hung exp=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule